// File: doc/BRIEF.md
# Serial Configuration Port for a Video Digitizer

This block is the receiving end of a three-wire serial link. A host uses the link to load the control settings of a video digitizer. It has three inputs: a select line (active low), a serial clock and a serial data line. While select is low, the block takes in one data bit on each rising edge of the serial clock, most significant bit first. When select rises, the block treats the last eleven bits it received as an 8-bit payload followed by a 3-bit address. It then writes that payload into one of five configuration registers. The block drives every decoded control field out as a separate output. These fields are the line counter, the clock delay, the polarity and high-impedance flags, the output force-low controls, the sync delay, and the PLL selects.

A system clock samples all three serial pins through a two-stage synchronizer. Serial clock edges and select edges are then detected in the system clock domain. A host frame is normally 16 bits long. It carries five leading don't-care bits, then the payload, then the address. Because only the final eleven bits count, the leading bits never reach the registers.

Top module: `cfg_serial_port`

## Requirements
- R1: After a reset, every configuration output is zero. This means the line counter is 0, all force-low controls are off, and the counter is enabled.
- R2: A bit is taken in only on a serial clock rising edge while select is low, and bits arrive most significant first. Serial clock edges that occur while select is high have no effect.
- R3: The registers change only when select rises. While select is low, all outputs hold their values, even after a complete frame has been shifted in.
- R4: At the select rising edge, received bits 10 to 3 (counted back from the last bit) form the payload, most significant first, and bits 2 to 0 form the address. Any earlier bits are ignored, and a frame of exactly eleven bits is valid.
- R5: A frame with fewer than eleven bits when select rises is dropped, and no register changes.
- R6: Address 1 writes line counter bits 7:0. Address 2 writes line counter bits 11:8 from payload bits 3:0, and payload bits 7:4 are ignored.
- R7: Address 3 loads three fields. Payload bits 5:0 set the clock delay, in steps of 1/32 of a clock. Bit 6 selects horizontal sync inversion (1 means inverted). Bit 7 sets the converter outputs to high impedance (1 means high impedance).
- R8: Address 4 loads the force-low controls and the sync delay. Payload bits 5:0 drive force_low[5:0], where a 1 holds that output low; the order is clock, inverted clock, sync, inverted sync, channel A sample clock, channel B sample clock. Payload bits 7:6 set the sync delay, from 0 to 3 clocks.
- R9: Address 5 loads six fields, one per payload bit group:
  - bit 0: clock source, where 1 means external.
  - bit 1: external clock type, where 1 means differential.
  - bit 2: counter disable.
  - bits 4:3: charge-pump code.
  - bit 5: VCO high range.
  - bits 7:6: divider code (0 to 3 for divide by 1, 2, 4 or 8).
- R10: A charge-pump code of 3 is reserved. In that case the charge-pump output keeps its previous value, and the other address-5 fields are still written.
- R11: Writes to addresses 0, 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low; a rising edge commits the frame |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| line_count | output | 12 | Line counter value |
| clk_delay | output | 6 | Clock delay in 1/32-clock steps |
| hsync_invert | output | 1 | Horizontal sync polarity invert |
| adc_hiz | output | 1 | Converter outputs high impedance |
| force_low | output | 6 | Per-output force-low controls |
| dsync_delay | output | 2 | Sync delay in clocks |
| clk_sel_ext | output | 1 | Clock source is external |
| ext_clk_pecl | output | 1 | External clock is differential |
| counter_off | output | 1 | Line counter disabled |
| cp_code | output | 2 | Charge-pump current code |
| vco_high | output | 1 | VCO high range select |
| div_code | output | 2 | Output divider code |

## Verification
The bench sends 16-bit frames that begin with a nonzero don't-care prefix. With such frames, any misalignment of the payload or address window shows up as wrong field values. It also sends frames of exactly eleven bits and of ten bits, which separates the commit threshold from an off-by-one error. Payloads are chosen so that every field of a register takes a different value, including 0xFF to the unused addresses and a high nibble on address 2, so a swapped or leaked field is caught. Two further patterns cover timing. In one, serial clock pulses are sent while select is high. In the other, outputs are observed while select is still low after a full frame. These show whether shifting and committing are gated by the select level and by its edge.

// File: rtl/cfgsp_pkg.sv
// Shared constants and the configuration record for the serial configuration port.
// Assumes a 3-bit address and an 8-bit payload per frame.
package cfgsp_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 12;
    localparam int DLY_W     = 6;
    localparam int NUM_FORCE = 6;
    localparam int FRAME_MIN = ADDR_W + DATA_W;
    localparam int CNT_HI_W  = CNT_W - DATA_W;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_TIMING = 3'd3;
    localparam logic [ADDR_W-1:0] A_OUTS   = 3'd4;
    localparam logic [ADDR_W-1:0] A_PLL    = 3'd5;

    localparam logic [1:0] CP_RSVD = 2'd3;

    typedef struct packed {
        logic [CNT_W-1:0]     line_count;
        logic [DLY_W-1:0]     clk_delay;
        logic                 hsync_invert;
        logic                 adc_hiz;
        logic [NUM_FORCE-1:0] force_low;
        logic [1:0]           dsync_delay;
        logic                 clk_sel_ext;
        logic                 ext_clk_pecl;
        logic                 counter_off;
        logic [1:0]           cp_code;
        logic                 vco_high;
        logic [1:0]           div_code;
    } cfg_t;
endpackage

// File: rtl/cfgsp_sync.sv
// Multi-stage synchronizer with one extra delay stage for edge detection.
// Assumes the inputs are asynchronous, slow level signals; q is the last
// synchronizing stage and q_d is q delayed by one clock.
module cfgsp_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] stg [STAGES+1];

    // Shift the raw pins through the synchronizer chain plus one delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q   = stg[STAGES-1];
    assign q_d = stg[STAGES];
endmodule

// File: rtl/cfgsp_shifter.sv
// Frame receiver: shifts serial bits in while select is low and flags a
// commit at the select rising edge when at least FRAME_MIN bits arrived.
// Assumes edge strobes are one system clock wide.
module cfgsp_shifter
    import cfgsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              sel_rise,
    output logic              commit,
    output logic [ADDR_W-1:0] frm_addr,
    output logic [DATA_W-1:0] frm_data
);
    localparam int BCNT_W = $clog2(FRAME_MIN + 1);

    logic [FRAME_MIN-1:0] shreg;
    logic [BCNT_W-1:0]    bcnt;

    // Shift register, newest bit at the LSB so the address lands at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[FRAME_MIN-2:0], bit_in};
    end

    // Saturating bit counter, cleared when the frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bcnt <= '0;
        else if (sel_rise)
            bcnt <= '0;
        else if (shift_en && (bcnt != BCNT_W'(FRAME_MIN)))
            bcnt <= bcnt + 1'b1;
    end

    assign commit   = sel_rise && (bcnt == BCNT_W'(FRAME_MIN));
    assign frm_addr = shreg[ADDR_W-1:0];
    assign frm_data = shreg[FRAME_MIN-1:ADDR_W];
endmodule

// File: rtl/cfgsp_regfile.sv
// Configuration registers: decodes a committed address and payload into
// the packed control record. Assumes commit is a single-cycle strobe.
module cfgsp_regfile
    import cfgsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cfg_t              cfg
);
    // Write the addressed fields; unused addresses and a reserved pump code are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (commit) begin
            case (addr)
                A_CNT_LO: cfg.line_count[DATA_W-1:0]     <= data;
                A_CNT_HI: cfg.line_count[CNT_W-1:DATA_W] <= data[CNT_HI_W-1:0];
                A_TIMING: begin
                    cfg.clk_delay    <= data[DLY_W-1:0];
                    cfg.hsync_invert <= data[6];
                    cfg.adc_hiz      <= data[7];
                end
                A_OUTS: begin
                    cfg.force_low   <= data[NUM_FORCE-1:0];
                    cfg.dsync_delay <= data[7:6];
                end
                A_PLL: begin
                    cfg.clk_sel_ext  <= data[0];
                    cfg.ext_clk_pecl <= data[1];
                    cfg.counter_off  <= data[2];
                    if (data[4:3] != CP_RSVD) cfg.cp_code <= data[4:3];
                    cfg.vco_high     <= data[5];
                    cfg.div_code     <= data[7:6];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_serial_port.sv
// Top of the serial configuration port: synchronizes the three serial pins,
// receives frames and drives the decoded control fields. Assumes the serial
// clock phases each span several system clocks.
module cfg_serial_port
    import cfgsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdata,
    output logic [CNT_W-1:0]     line_count,
    output logic [DLY_W-1:0]     clk_delay,
    output logic                 hsync_invert,
    output logic                 adc_hiz,
    output logic [NUM_FORCE-1:0] force_low,
    output logic [1:0]           dsync_delay,
    output logic                 clk_sel_ext,
    output logic                 ext_clk_pecl,
    output logic                 counter_off,
    output logic [1:0]           cp_code,
    output logic                 vco_high,
    output logic [1:0]           div_code
);
    logic [2:0]        pin_q, pin_qd;
    logic              shift_en, sel_rise, commit_vld;
    logic [ADDR_W-1:0] frm_addr;
    logic [DATA_W-1:0] frm_data;
    cfg_t              cfg_q;

    // Pin order: {cs_n, sclk, sdata}; select idles high after reset.
    cfgsp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) i_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdata}),
        .q(pin_q), .q_d(pin_qd)
    );

    assign shift_en = pin_q[1] && !pin_qd[1] && !pin_q[2];
    assign sel_rise = pin_q[2] && !pin_qd[2];

    cfgsp_shifter i_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(pin_q[0]),
        .sel_rise(sel_rise), .commit(commit_vld),
        .frm_addr(frm_addr), .frm_data(frm_data)
    );

    cfgsp_regfile i_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit_vld),
        .addr(frm_addr), .data(frm_data), .cfg(cfg_q)
    );

    assign line_count   = cfg_q.line_count;
    assign clk_delay    = cfg_q.clk_delay;
    assign hsync_invert = cfg_q.hsync_invert;
    assign adc_hiz      = cfg_q.adc_hiz;
    assign force_low    = cfg_q.force_low;
    assign dsync_delay  = cfg_q.dsync_delay;
    assign clk_sel_ext  = cfg_q.clk_sel_ext;
    assign ext_clk_pecl = cfg_q.ext_clk_pecl;
    assign counter_off  = cfg_q.counter_off;
    assign cp_code      = cfg_q.cp_code;
    assign vco_high     = cfg_q.vco_high;
    assign div_code     = cfg_q.div_code;
endmodule

// File: rtl/cfgsp_checker.sv
// Property checker for the serial configuration port, bound to the top.
// Assumes access to the commit strobe and the received frame fields.
module cfgsp_checker
    import cfgsp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic [ADDR_W-1:0] frm_addr,
    input logic [DATA_W-1:0] frm_data,
    input cfg_t              cfg_q
);
    AST_RESET_ZERO: assert property (@(posedge clk) $rose(rst_n) |-> (cfg_q == '0)); // R1
    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_q)); // R3
    AST_CNT_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frm_addr == A_CNT_HI) |=>
        (cfg_q.line_count[CNT_W-1:DATA_W] == $past(frm_data[CNT_HI_W-1:0]))); // R6
    AST_DELAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frm_addr == A_TIMING) |=>
        (cfg_q.clk_delay == $past(frm_data[DLY_W-1:0]))); // R7
    AST_CP_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.cp_code != CP_RSVD); // R10
    AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (frm_addr == 3'd0 || frm_addr == 3'd6 || frm_addr == 3'd7)) |=>
        $stable(cfg_q)); // R11
endmodule

bind cfg_serial_port cfgsp_checker i_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit_vld),
    .frm_addr(frm_addr), .frm_data(frm_data), .cfg_q(cfg_q)
);

// File: tb/test_cfg_serial_port.sv
// Directed bench for the serial configuration port.
module test_cfg_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
    logic [11:0] line_count;
    logic [5:0]  clk_delay, force_low;
    logic        hsync_invert, adc_hiz, clk_sel_ext, ext_clk_pecl, counter_off, vco_high;
    logic [1:0]  dsync_delay, cp_code, div_code;
    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cfg_serial_port i_cfg_serial_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
        .line_count(line_count), .clk_delay(clk_delay), .hsync_invert(hsync_invert),
        .adc_hiz(adc_hiz), .force_low(force_low), .dsync_delay(dsync_delay),
        .clk_sel_ext(clk_sel_ext), .ext_clk_pecl(ext_clk_pecl), .counter_off(counter_off),
        .cp_code(cp_code), .vco_high(vco_high), .div_code(div_code)
    );

    wire [35:0] obs = {line_count, clk_delay, hsync_invert, adc_hiz, force_low, dsync_delay,
                       clk_sel_ext, ext_clk_pecl, counter_off, cp_code, vco_high, div_code};

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = v[i];
            wait_clk(6);
            sclk = 1'b1;
            wait_clk(13);
            sclk = 1'b0;
            wait_clk(7);
        end
    endtask

    task automatic end_frame();
        wait_clk(6);
        cs_n = 1'b1;
        wait_clk(16);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        shift_bits({16'h0, 5'b10110, d, a}, 16);
        end_frame();
    endtask

    task automatic t_reset();
        check("R1 reset", obs, 36'h0);
    endtask

    task automatic t_counter();
        write_reg(3'd1, 8'hA5);
        write_reg(3'd2, 8'hF7);
        check("R6 counter", {24'h0, line_count}, 36'h7A5);
        check("R4 junk prefix", {24'h0, line_count}, 36'h7A5);
    endtask

    task automatic t_timing();
        write_reg(3'd3, 8'hEB);
        check("R7 delay/pol/hiz", {28'h0, clk_delay, hsync_invert, adc_hiz}, {28'h0, 6'h2B, 2'b11});
        write_reg(3'd3, 8'h15);
        check("R7 second value", {28'h0, clk_delay, hsync_invert, adc_hiz}, {28'h0, 6'h15, 2'b00});
    endtask

    task automatic t_outs();
        write_reg(3'd4, 8'hA9);
        check("R8 force/dsync", {28'h0, force_low, dsync_delay}, {28'h0, 6'h29, 2'd2});
    endtask

    task automatic t_pll();
        write_reg(3'd5, 8'hF5);
        check("R9 pll fields", {27'h0, clk_sel_ext, ext_clk_pecl, counter_off, cp_code, vco_high, div_code},
              {27'h0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 2'd3});
        write_reg(3'd5, 8'h5A);
        check("R10 reserved pump code", {27'h0, clk_sel_ext, ext_clk_pecl, counter_off, cp_code, vco_high, div_code},
              {27'h0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 2'd1});
    endtask

    task automatic t_unused();
        logic [35:0] snap;
        snap = obs;
        write_reg(3'd0, 8'hFF);
        check("R11 addr0", obs, snap);
        write_reg(3'd6, 8'hFF);
        check("R11 addr6", obs, snap);
        write_reg(3'd7, 8'hFF);
        check("R11 addr7", obs, snap);
    endtask

    task automatic t_lengths();
        logic [35:0] snap;
        snap = obs;
        shift_bits({21'h0, 8'h3C, 3'd1}, 10);
        end_frame();
        check("R5 short frame", obs, snap);
        shift_bits({21'h0, 8'h3C, 3'd1}, 11);
        end_frame();
        check("R4 eleven bits", {24'h0, line_count}, 36'h73C);
    endtask

    task automatic t_idle_clock();
        logic [35:0] snap;
        snap = obs;
        sdata = 1'b0;
        for (int i = 0; i < 3; i++) begin
            wait_clk(6); sclk = 1'b1; wait_clk(13); sclk = 1'b0; wait_clk(7);
        end
        shift_bits({24'h0, 8'hFF}, 8);
        end_frame();
        check("R2 clock while deselected", obs, snap);
    endtask

    task automatic t_commit_edge();
        logic [35:0] snap;
        snap = obs;
        shift_bits({16'h0, 5'b11111, 8'h2C, 3'd3}, 16);
        wait_clk(30);
        check("R3 hold while selected", obs, snap);
        end_frame();
        check("R3 commit at rise", {30'h0, clk_delay}, 36'h2C);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_counter();
        t_timing();
        t_outs();
        t_pll();
        t_unused();
        t_lengths();
        t_idle_clock();
        t_commit_edge();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule